// File: doc/BRIEF.md
# Multiplexed-Bus Clock Register Interface

This block is the host-facing front end and byte storage of a clock/calendar device. The device has a 128-byte address space. Bytes 0x00 to 0x0D hold clock and control registers, and bytes 0x0E to 0x7F are general-purpose storage. A host reaches them over one 8-bit bus that carries the address first and the data afterwards. The address is captured on the falling edge of the address strobe. The data phase is then framed by the data strobe and the read/write line. Two timing families are supported, and a level input picks one of them while the block runs.

All pins are sampled on the block clock and handled as synchronous levels. Some bytes belong to neighbouring blocks and are brought in through input ports. The status register (0x0C), the validity register (0x0D) and the top bit of the rate register (0x0A) read from those ports, and host writes to them are dropped. A RAM-clear input, held low for a set number of slow ticks, fills every user byte with 0xFF and leaves the clock and control bytes as they were. While the block reset is low, nothing the host does reaches storage and the bus is never driven.

Top module: `mbus_rtc_regs`

## Requirements
- R1: The byte address is bits [6:0] of `ad_in`, taken at the first clock edge where `as_i` reads low after reading high. At any other edge the held address does not change.
- R2: The address is captured even while `ce_n` is high. While `ce_n` is high no write lands and `ad_oe` stays 0.
- R3: With `bus_mot`=0, a read is active while `ds_i`=0 and `ce_n`=0. One edge later `ad_oe`=1 and `ad_out` holds the addressed byte. One edge after `ds_i` returns high, `ad_oe` is 0.
- R4: With `bus_mot`=0, a write stores `ad_in` at the edge where `rw_i` is first seen high after being low, provided `ce_n`=0 at that edge.
- R5: With `bus_mot`=1, a read is active while `ds_i`=1, `rw_i`=1 and `ce_n`=0, with the same one-edge latency as R3.
- R6: With `bus_mot`=1, a write stores `ad_in` at the edge where `ds_i` is first seen low after being high, provided `rw_i`=0 and `ce_n`=0 at that edge.
- R7: A read of 0x0C returns `ro_c` and a read of 0x0D returns `ro_d`. Host writes to these two addresses have no effect.
- R8: Bit 7 of 0x0A always reads `ro_a7`. Bits 6:0 of 0x0A are stored by host writes.
- R9: While `rst_n`=0, `ad_oe` is 0 and host writes do not change storage.
- R10: If `clr_n` is low across `CLR_TICKS` rising pulses of `tick`, every byte 0x0E to 0x7F reads 0xFF. After fewer pulses, no byte changes. Raising `clr_n` restarts the count.
- R11: The RAM clear of R10 leaves bytes 0x00 to 0x0D unchanged.
- R12: Bit 7 of the address phase is ignored, so 0x80+n reaches byte n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks bus access |
| ad_in | input | 8 | Address/data bus, input side |
| ad_out | output | 8 | Address/data bus, read data |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| as_i | input | 1 | Address strobe, high pulse |
| ds_i | input | 1 | Data strobe (read low for `bus_mot`=0, enable high for `bus_mot`=1) |
| rw_i | input | 1 | Write low for `bus_mot`=0; direction, high = read, for `bus_mot`=1 |
| ce_n | input | 1 | Active-low chip enable for the data phase |
| bus_mot | input | 1 | Timing family select, 1 = enable/direction style, 0 = separate read/write strobes |
| clr_n | input | 1 | Active-low RAM-clear request |
| tick | input | 1 | Slow timing pulse that measures the clear hold time |
| ro_a7 | input | 1 | Value read as bit 7 of byte 0x0A |
| ro_c | input | 8 | Value read at byte 0x0C |
| ro_d | input | 8 | Value read at byte 0x0D |

## Verification
A wrong held address shows up on the very next read as the byte of a neighbouring location. The bench catches it by giving every address its own arithmetic pattern. A missed or spurious write commit appears one read later as a stale or altered byte. Swapping the timing families in either mode shows as a drive enable that stays 0 or a write that never lands. A clear counter that is off by one is caught when a user byte reads 0xFF one tick too early, or reads its old value after the full count.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
   typedef enum logic {
      BUS_STROBES = 1'b0,
      BUS_DIRSEL  = 1'b1
   } bus_kind_e;

   localparam int MBR_REG_RATE   = 10;
   localparam int MBR_REG_STATUS = 12;
   localparam int MBR_REG_VALID  = 13;
   localparam int MBR_USER_BASE  = 14;
endpackage

// File: rtl/mbr_bus_ctrl.sv
module mbr_bus_ctrl
   import mbr_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ad_in,
   input  logic              as_i,
   input  logic              ds_i,
   input  logic              rw_i,
   input  logic              ce_n,
   input  logic              bus_mot,
   output logic [ADDR_W-1:0] addr_o,
   output logic              we_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              rd_o
);
   initial assert (ADDR_W < DATA_W) else $fatal(1, "address must fit in the bus");

   logic as_q, ds_q, rw_q;
   logic [ADDR_W-1:0] addr_q;
   bus_kind_e kind;

   assign kind = bus_kind_e'(bus_mot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_q   <= 1'b0;
         ds_q   <= 1'b0;
         rw_q   <= 1'b1;
         addr_q <= '0;
      end else begin
         as_q <= as_i;
         ds_q <= ds_i;
         rw_q <= rw_i;
         if (as_q && !as_i) addr_q <= ad_in[ADDR_W-1:0];
      end
   end

   logic commit;
   always_comb begin
      if (kind == BUS_DIRSEL) begin
         commit = ds_q && !ds_i && !rw_i;
         rd_o   = !ce_n && ds_i && rw_i;
      end else begin
         commit = !rw_q && rw_i;
         rd_o   = !ce_n && !ds_i;
      end
   end

   assign we_o    = rst_n && !ce_n && commit;
   assign wdata_o = ad_in;
   assign addr_o  = addr_q;

   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (as_q == as_i) |=> $stable(addr_q));
endmodule

// File: rtl/mbr_clear_timer.sv
module mbr_clear_timer #(
   parameter int CLR_TICKS = 103
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr_n,
   output logic fill_o
);
   localparam int CW = $clog2(CLR_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(CLR_TICKS - 1);
   localparam logic [CW-1:0] FULL = CW'(CLR_TICKS);

   initial assert (CLR_TICKS >= 1) else $fatal(1, "clear needs at least one tick");

   logic [CW-1:0] cnt_q;
   logic tick_q;
   logic tick_rise;

   assign tick_rise = tick && !tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= tick;
         if (clr_n) cnt_q <= '0;
         else if (tick_rise && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign fill_o = !clr_n && tick_rise && (cnt_q == LAST);

   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
   // R10
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_n |=> (cnt_q == '0));
endmodule

// File: rtl/mbr_store.sv
module mbr_store
   import mbr_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fill,
   input  logic              ro_a7,
   input  logic [DATA_W-1:0] ro_c,
   input  logic [DATA_W-1:0] ro_d,
   output logic [DATA_W-1:0] rdata
);
   localparam int NUM_BYTES = 1 << ADDR_W;
   localparam logic [DATA_W-1:0] RATE_MASK = {1'b0, {(DATA_W-1){1'b1}}};

   initial assert (NUM_BYTES > MBR_USER_BASE) else $fatal(1, "no room for user bytes");

   logic [DATA_W-1:0] mem [NUM_BYTES];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (fill && i >= MBR_USER_BASE)
            mem[i] <= '1;
         else if (we && int'(addr) == i && i != MBR_REG_STATUS && i != MBR_REG_VALID)
            mem[i] <= (i == MBR_REG_RATE) ? (wdata & RATE_MASK) : wdata;
      end
   end

   always_comb begin
      case (int'(addr))
         MBR_REG_STATUS: rdata = ro_c;
         MBR_REG_VALID:  rdata = ro_d;
         MBR_REG_RATE:   rdata = {ro_a7, mem[MBR_REG_RATE][DATA_W-2:0]};
         default:        rdata = mem[addr];
      endcase
   end

   // R10
   fill_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill |=> (mem[NUM_BYTES-1] == '1));
   // R11
   ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill && !we) |=> (mem[0] == $past(mem[0])));
   // R4
   write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !fill && int'(addr) == MBR_USER_BASE) |=> (mem[MBR_USER_BASE] == $past(wdata)));
endmodule

// File: rtl/mbus_rtc_regs.sv
module mbus_rtc_regs #(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int CLR_TICKS = 103
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic              as_i,
   input  logic              ds_i,
   input  logic              rw_i,
   input  logic              ce_n,
   input  logic              bus_mot,
   input  logic              clr_n,
   input  logic              tick,
   input  logic              ro_a7,
   input  logic [DATA_W-1:0] ro_c,
   input  logic [DATA_W-1:0] ro_d
);
   logic [ADDR_W-1:0] addr;
   logic              we, rd, fill;
   logic [DATA_W-1:0] wdata, rdata;

   mbr_bus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .as_i(as_i), .ds_i(ds_i),
      .rw_i(rw_i), .ce_n(ce_n), .bus_mot(bus_mot), .addr_o(addr),
      .we_o(we), .wdata_o(wdata), .rd_o(rd)
   );

   mbr_clear_timer #(.CLR_TICKS(CLR_TICKS)) u_clr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr_n(clr_n), .fill_o(fill)
   );

   mbr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
      .fill(fill), .ro_a7(ro_a7), .ro_c(ro_c), .ro_d(ro_d), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ad_oe  <= 1'b0;
         ad_out <= '0;
      end else begin
         ad_oe  <= rd;
         ad_out <= rd ? rdata : '0;
      end
   end

   // R2
   oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !ad_oe);
endmodule

// File: tb/mbus_rtc_regs_bench.sv
module mbus_rtc_regs_bench;
   localparam int PER = 10;
   localparam int CT  = 12;

   logic clk = 0, rst_n = 0;
   logic [7:0] ad_in = 0, ro_c = 8'hC3, ro_d = 8'h5A;
   logic as_i = 0, ds_i = 1, rw_i = 1, ce_n = 1, bus_mot = 0;
   logic clr_n = 1, tick = 0, ro_a7 = 1;
   logic [7:0] ad_out;
   logic ad_oe;
   int total = 0, bad = 0;
   logic [7:0] model [128];

   always #(PER/2) clk = ~clk;

   mbus_rtc_regs #(.CLR_TICKS(CT)) u_mbus_rtc_regs (
      .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
      .as_i(as_i), .ds_i(ds_i), .rw_i(rw_i), .ce_n(ce_n), .bus_mot(bus_mot),
      .clr_n(clr_n), .tick(tick), .ro_a7(ro_a7), .ro_c(ro_c), .ro_d(ro_d)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] expect_rd(input int a);
      if (a == 12) return ro_c;
      if (a == 13) return ro_d;
      if (a == 10) return {ro_a7, model[10][6:0]};
      return model[a];
   endfunction

   function automatic void note_wr(input int a, input logic [7:0] d);
      if (a == 10) model[a] = {1'b0, d[6:0]};
      else if (a != 12 && a != 13) model[a] = d;
   endfunction

   task automatic set_mode(input logic m);
      @(negedge clk);
      ce_n = 1; rw_i = 1; ds_i = m ? 1'b0 : 1'b1; bus_mot = m;
      @(negedge clk);
   endtask

   task automatic latch(input logic [7:0] a);
      @(negedge clk); as_i = 1; ad_in = a;
      @(negedge clk); as_i = 0;
      @(negedge clk);
   endtask

   task automatic wr_phase(input logic [7:0] d, input logic cen);
      ce_n = cen; ad_in = d;
      if (bus_mot) begin rw_i = 0; ds_i = 1; end else rw_i = 0;
      @(negedge clk);
      if (bus_mot) ds_i = 0; else rw_i = 1;
      @(negedge clk);
      ce_n = 1; rw_i = 1;
   endtask

   task automatic rd_phase(input string tag, input int a, input logic cen);
      ce_n = cen;
      if (bus_mot) begin rw_i = 1; ds_i = 1; end else ds_i = 0;
      @(negedge clk);
      chk({tag, " oe"}, {7'd0, ad_oe}, {7'd0, !cen});
      if (!cen) chk({tag, " data"}, ad_out, expect_rd(a));
      ds_i = bus_mot ? 1'b0 : 1'b1;
      @(negedge clk);
      chk({tag, " oe off"}, {7'd0, ad_oe}, 8'd0);
      ce_n = 1;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
   endtask

   initial begin
      #(PER * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 128; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 reset oe", {7'd0, ad_oe}, 8'd0);
      rst_n = 1;
      // R4 write every byte with separate strobes, R3 read back, R7 R8 fixed bytes
      set_mode(0);
      for (int a = 0; a < 128; a++) begin
         latch(8'(a)); wr_phase(8'((a * 37 + 5) & 255), 0); note_wr(a, 8'((a * 37 + 5) & 255));
      end
      for (int a = 0; a < 128; a++) begin
         latch(8'(a)); rd_phase("R3 R4 R7 R8 sweep", a, 0);
      end
      // R6 writes with enable/direction timing, R5 reads
      set_mode(1);
      for (int a = 0; a < 128; a += 3) begin
         latch(8'(a)); wr_phase(8'(a) ^ 8'hA5, 0); note_wr(a, 8'(a) ^ 8'hA5);
      end
      for (int a = 0; a < 128; a++) begin
         latch(8'(a)); rd_phase("R5 R6 R7 sweep", a, 0);
      end
      // R8 fixed top bit follows its port
      ro_a7 = 0;
      latch(8'd10); rd_phase("R8 rate bit7", 10, 0);
      ro_c = 8'h3C;
      latch(8'd12); wr_phase(8'h77, 0); rd_phase("R7 status", 12, 0);
      // R12 top address bit ignored
      latch(8'h80 | 8'h21); rd_phase("R12 alias", 8'h21, 0);
      latch(8'hFF); wr_phase(8'h6E, 0); note_wr(8'h7F, 8'h6E);
      latch(8'h7F); rd_phase("R12 alias write", 8'h7F, 0);
      // R2 address captured without chip enable, no access
      set_mode(0);
      ce_n = 1; latch(8'h30); rd_phase("R2 no drive", 8'h30, 1);
      wr_phase(8'hEE, 1);
      ad_in = 8'h31; @(negedge clk);
      // R1 bus changes without a strobe do not move the address
      rd_phase("R1 R2 held address", 8'h30, 0);
      // R9 accesses during reset are ignored
      rst_n = 0;
      latch(8'h40); wr_phase(8'h99, 0); rd_phase("R9 under reset", 8'h40, 1);
      rst_n = 1;
      latch(8'h40); rd_phase("R9 after reset", 8'h40, 0);
      // R10 R11 RAM clear
      @(negedge clk); clr_n = 0;
      for (int t = 0; t < CT - 1; t++) pulse_tick();
      latch(8'h0E); rd_phase("R10 early", 8'h0E, 0);
      latch(8'h7F); rd_phase("R10 early top", 8'h7F, 0);
      clr_n = 1; @(negedge clk); clr_n = 0;
      pulse_tick();
      latch(8'h0E); rd_phase("R10 restart", 8'h0E, 0);
      for (int t = 0; t < CT - 1; t++) pulse_tick();
      clr_n = 1;
      for (int a = 14; a < 128; a++) model[a] = 8'hFF;
      for (int a = 0; a < 128; a++) begin
         latch(8'(a));
         rd_phase(a < 14 ? "R11 kept" : "R10 filled", a, 0);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule